// File: doc/BRIEF.md
# Rotor-Synchronized Counting-Rate Selector

This block takes a fast reference clock and a once-per-revolution pulse from a spinning rotor that arrives with no fixed phase relation to that clock. It resamples the pulse onto the fast clock and emits a one-cycle strobe at each leading edge. It keeps an odd/even revolution flag. It also produces a counting-clock enable that runs at one of two rates derived from the fast clock: the fast clock divided by `FAST_DIV`, or divided by `SLOW_DIV`.

Between successive strobes the block counts enable pulses and latches the total as the rotor period. That measurement also picks the rate. A slow rotor needs the slower rate so the count stays inside `CNT_W` bits. A fast rotor needs the faster rate so a revolution still holds enough counts for fine angular resolution. The up and down switch points are far apart, which gives hysteresis. Because of this gap, the rate does not chatter while the rotor speeds up or slows down.

A rate change takes effect only at a revolution boundary. A stopped rotor is reported through a status bit. Software reads the period and the status through a plain registered read port. There is no handshake and no back-pressure: every address returns data exactly one clock later.

Top module: `rotor_sync_clksel`

## Requirements
- R1: Each low-to-high transition of `rotor_i` produces exactly one `sync_strobe_o` pulse, one clock wide, no matter how long `rotor_i` stays high.
- R2: `odd_even_o` resets to 0 and inverts on the clock edge that ends each strobe, so it changes once per revolution.
- R3: `count_en_o` is a one-clock pulse. It fires once every `FAST_DIV` clocks while `rate_fast_o` is 1, and once every `SLOW_DIV` clocks while it is 0 (in 64 clocks: 32 pulses at divide-by-2, 4 at divide-by-16).
- R4: At each strobe, the number of `count_en_o` pulses since the previous strobe (strobe cycle included) is latched as the period. It is read at address 0.
- R5: The period latched at the first strobe after reset is marked invalid, because no earlier boundary exists.
- R6: While slow, a valid, unsaturated period below `UP_TH` switches to the fast rate. The new rate applies from the clock after the strobe. A period equal to `UP_TH` keeps the slow rate.
- R7: While fast, a period above `DOWN_TH` switches to the slow rate. Any fast period from `UP_TH` up to `DOWN_TH` keeps the fast rate (hysteresis).
- R8: The period latched at the strobe that causes a rate change is marked invalid.
- R9: If the period counter reaches all ones, the stall bit sets and stays set until the next strobe. At that strobe the bit clears, the latched period is all ones and invalid, and a fast rate drops to slow.
- R10: The read port is registered, with one clock of latency. Address 0 returns the period. Address 1 returns status: bit 0 is the rate (1 = fast), bit 1 is period valid, bit 2 is stall, and bit 3 is odd/even. Higher status bits and addresses 2 and 3 read zero.
- R11: After reset the rate is slow, the period is 0 and invalid, stall is 0, odd/even is 0 and `rd_data_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rotor_i | input | 1 | Asynchronous once-per-revolution rotor pulse |
| sync_strobe_o | output | 1 | One-clock strobe at each synchronized leading edge |
| odd_even_o | output | 1 | Revolution parity flag |
| count_en_o | output | 1 | Counting-clock enable at the selected rate |
| rate_fast_o | output | 1 | 1 when the fast counting rate is selected |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | CNT_W | Registered read data |

## Verification
A rising edge on `rotor_i` is captured at one clock edge. The strobe is visible after the next edge. Period, valid flag, rate and parity all update on the edge after that. A read address applied after any edge returns its data after the following edge. The bench scoreboard pushes one expected record for each rotor edge. Its monitor waits for the strobe at a falling edge, then checks rate, parity and strobe width one falling edge later. It then steps the read address through period and status on the next two falling edges. Rotor periods are multiples of 16 clocks, so the expected tick count is exact in both rates.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  localparam logic [1:0] ADDR_PERIOD = 2'd0;
  localparam logic [1:0] ADDR_STATUS = 2'd1;

  localparam int ST_FAST   = 0;
  localparam int ST_VALID  = 1;
  localparam int ST_STALL  = 2;
  localparam int ST_PARITY = 3;
  localparam int ST_BITS   = 4;

  typedef struct packed {
    logic parity;
    logic stall;
    logic valid;
    logic fast;
  } rsc_status_t;
endpackage

// File: rtl/rsc_pulse_sync.sv
module rsc_pulse_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rotor_i,
  output logic strobe_o,
  output logic parity_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              parity_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q   <= '0;
      prev_q   <= 1'b0;
      parity_q <= 1'b0;
    end else begin
      sync_q   <= {sync_q[STAGES-2:0], rotor_i};
      prev_q   <= sync_q[STAGES-1];
      parity_q <= parity_q ^ strobe_o;
    end
  end

  assign strobe_o = sync_q[STAGES-1] & ~prev_q;
  assign parity_o = parity_q;

  a_r1_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |=> !strobe_o);
  a_r2_parity_flips: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |=> (parity_o != $past(parity_o)));
  a_r2_parity_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_o |=> $stable(parity_o));
endmodule

// File: rtl/rsc_rate_gen.sv
module rsc_rate_gen #(
  parameter int FAST_DIV = 2,
  parameter int SLOW_DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fast_i,
  output logic tick_o
);
  localparam int PW = $clog2(SLOW_DIV);
  localparam int FW = (FAST_DIV > 1) ? $clog2(FAST_DIV) : 1;

  logic [PW-1:0] pre_q;
  logic          fast_tick;
  logic          slow_tick;

  always_ff @(posedge clk) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + 1'b1;
  end

  generate
    if (FAST_DIV > 1) begin : g_fdiv
      assign fast_tick = &pre_q[FW-1:0];
    end else begin : g_fone
      assign fast_tick = 1'b1;
    end
  endgenerate

  assign slow_tick = &pre_q;
  assign tick_o    = fast_i ? fast_tick : slow_tick;

  a_r3_slow_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && !fast_i) |=> !tick_o);
endmodule

// File: rtl/rsc_period_meter.sv
module rsc_period_meter #(
  parameter int CNT_W   = 16,
  parameter int UP_TH   = 5000,
  parameter int DOWN_TH = 60000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] period_o,
  output logic             valid_o,
  output logic             stall_o,
  output logic             fast_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] UP_V    = CNT_W'(UP_TH);
  localparam logic [CNT_W-1:0] DOWN_V  = CNT_W'(DOWN_TH);

  logic [CNT_W-1:0] cnt_q, cnt_plus;
  logic             sat;
  logic             started_q;
  logic             go_up, go_down;

  always_comb begin
    sat      = (cnt_q == CNT_MAX);
    cnt_plus = (tick_i && !sat) ? cnt_q + 1'b1 : cnt_q;
    go_up    = !fast_o && started_q && !sat && (cnt_plus < UP_V);
    go_down  = fast_o && (sat || (cnt_plus > DOWN_V));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      period_o  <= '0;
      valid_o   <= 1'b0;
      stall_o   <= 1'b0;
      fast_o    <= 1'b0;
      started_q <= 1'b0;
    end else if (strobe_i) begin
      cnt_q     <= '0;
      period_o  <= cnt_plus;
      valid_o   <= started_q && !sat && !go_up && !go_down;
      stall_o   <= 1'b0;
      started_q <= 1'b1;
      if (go_up)   fast_o <= 1'b1;
      if (go_down) fast_o <= 1'b0;
    end else begin
      cnt_q <= cnt_plus;
      if (sat) stall_o <= 1'b1;
    end
  end

  a_r6_rate_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_i |=> $stable(fast_o));
  a_r8_switch_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_o != $past(fast_o)) |-> !valid_o);
  a_r9_stall_clears: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_i |=> !stall_o);
  a_r9_stall_period: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall_o) |-> (cnt_q == CNT_MAX));
endmodule

// File: rtl/rotor_sync_clksel.sv
module rotor_sync_clksel #(
  parameter int CNT_W       = 16,
  parameter int FAST_DIV    = 2,
  parameter int SLOW_DIV    = 16,
  parameter int UP_TH       = 5000,
  parameter int DOWN_TH     = 60000,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rotor_i,
  output logic             sync_strobe_o,
  output logic             odd_even_o,
  output logic             count_en_o,
  output logic             rate_fast_o,
  input  logic [1:0]       rd_addr_i,
  output logic [CNT_W-1:0] rd_data_o
);
  import rsc_pkg::*;

  logic [CNT_W-1:0] period;
  logic             valid, stall, fast, strobe, parity, tick;
  rsc_status_t      status;
  logic [CNT_W-1:0] rd_next;

  rsc_pulse_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .rotor_i(rotor_i),
    .strobe_o(strobe), .parity_o(parity));

  rsc_rate_gen #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_rate (
    .clk(clk), .rst_n(rst_n), .fast_i(fast), .tick_o(tick));

  rsc_period_meter #(.CNT_W(CNT_W), .UP_TH(UP_TH), .DOWN_TH(DOWN_TH)) u_meter (
    .clk(clk), .rst_n(rst_n), .strobe_i(strobe), .tick_i(tick),
    .period_o(period), .valid_o(valid), .stall_o(stall), .fast_o(fast));

  always_comb begin
    status.fast   = fast;
    status.valid  = valid;
    status.stall  = stall;
    status.parity = parity;
    rd_next = '0;
    case (rd_addr_i)
      ADDR_PERIOD: rd_next = period;
      ADDR_STATUS: rd_next[ST_BITS-1:0] = status;
      default:     rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data_o <= '0;
    else        rd_data_o <= rd_next;
  end

  assign sync_strobe_o = strobe;
  assign odd_even_o    = parity;
  assign count_en_o    = tick;
  assign rate_fast_o   = fast;

  a_r10_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_i == ADDR_PERIOD) |=> (rd_data_o == $past(period)));
  a_r3_fast_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en_o && rate_fast_o) |=> !count_en_o);
endmodule

// File: tb/rotor_sync_clksel_test.sv
module rotor_sync_clksel_test;
  localparam int CNT_W = 8;
  localparam int UP_TH = 20;
  localparam int DOWN_TH = 200;
  localparam int MAXC = (1 << CNT_W) - 1;

  logic clk = 0, rst_n = 0, rotor = 0;
  logic [1:0] rd_addr = 0;
  logic strobe, parity, cen, fast;
  logic [CNT_W-1:0] rd_data;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct {
    bit chk_period; int period; bit valid; bit fast; bit parity;
  } exp_t;
  exp_t q[$];

  bit m_fast = 0, m_started = 0, m_par = 0;
  int last_gap = 0;

  always #5 clk = ~clk;

  rotor_sync_clksel #(.CNT_W(CNT_W), .FAST_DIV(2), .SLOW_DIV(16),
    .UP_TH(UP_TH), .DOWN_TH(DOWN_TH), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .rotor_i(rotor), .sync_strobe_o(strobe),
    .odd_even_o(parity), .count_en_o(cen), .rate_fast_o(fast),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    rd_addr = a;
    @(negedge clk);
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic model_edge();
    exp_t e;
    int c;
    bit sat, up, dn;
    e.chk_period = m_started;
    if (!m_started) begin
      e.period = 0; e.valid = 0; m_started = 1;
    end else begin
      c = m_fast ? last_gap / 2 : last_gap / 16;
      sat = (c >= MAXC);
      if (sat) c = MAXC;
      up = !m_fast && !sat && (c < UP_TH);
      dn = m_fast && (sat || c > DOWN_TH);
      e.period = c;
      e.valid = !sat && !up && !dn;
      if (up) m_fast = 1;
      if (dn) m_fast = 0;
    end
    m_par = !m_par;
    e.fast = m_fast; e.parity = m_par;
    q.push_back(e);
  endtask

  // rise, 8 clocks high, low for the rest of P clocks
  task automatic rev(input int p);
    model_edge();
    rotor = 1;
    repeat (8) @(negedge clk);
    rotor = 0;
    repeat (p - 8) @(negedge clk);
    last_gap = p;
  endtask

  task automatic rev_ticks(input int p, input int exp_ticks, input string req);
    int n = 0;
    model_edge();
    rotor = 1;
    repeat (8) @(negedge clk);
    rotor = 0;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (cen) n++;
    end
    check(req, n, exp_ticks);
    repeat (p - 72) @(negedge clk);
    last_gap = p;
  endtask

  task automatic rev_stall(input int p);
    int v;
    model_edge();
    rotor = 1;
    repeat (8) @(negedge clk);
    rotor = 0;
    repeat (p - 108) @(negedge clk);
    rd(2'd1, v);
    check("R9 stall bit set", (v >> 2) & 1, 1);
    repeat (98) @(negedge clk);
    last_gap = p;
  endtask

  // monitor: pops one record per strobe
  initial begin
    int v;
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n && strobe) begin
        if (q.size() == 0) begin
          errors++;
          $display("FAIL R1 unexpected strobe actual=1 expected=0");
        end else begin
          e = q.pop_front();
          @(negedge clk);
          check("R1 strobe one cycle", strobe, 0);
          check("R2 odd/even", parity, e.parity);
          check("R6/R7 rate", fast, e.fast);
          rd_addr = 2'd0;
          @(negedge clk);
          v = rd_data;
          if (e.chk_period) check("R4 period", v, e.period);
          rd_addr = 2'd1;
          @(negedge clk);
          v = rd_data;
          check(e.chk_period ? "R8 valid flag" : "R5 first invalid", (v >> 1) & 1, e.valid);
          check("R10 status fast bit", v & 1, e.fast);
          check("R10 status parity bit", (v >> 3) & 1, e.parity);
          check("R9 stall cleared", (v >> 2) & 1, 0);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R11 rate slow", fast, 0);
    check("R11 parity", parity, 0);
    check("R11 rd_data", rd_data, 0);
    rd(2'd0, v); check("R11 period zero", v, 0);
    rd(2'd1, v); check("R11 status zero", v, 0);
    rd(2'd2, v); check("R10 addr2 zero", v, 0);
    rd(2'd3, v); check("R10 addr3 zero", v, 0);
    rev(480);
    rev_ticks(480, 4, "R3 slow rate ticks");
    rev(256);                 // 30: stays slow
    rev(320);                 // 16: up to fast, invalid
    rev(320);                 // 160 fast: stays
    rev(416);                 // 160 fast: stays (hysteresis)
    rev(416);                 // 208: down to slow, invalid
    rev(320);                 // 26 slow
    rev(256);                 // 20 slow boundary: stays
    rev_ticks(320, 32, "R3 fast rate ticks"); // 16: to fast
    rev(400);                 // 160 fast
    rev_stall(1024);          // 200 fast: stays; then saturates
    rev_stall(4800);          // 255 sat: drops to slow
    rev(480);                 // 255 sat slow
    rev(480);                 // 30 slow
    model_edge();
    rotor = 1;
    repeat (8) @(negedge clk);
    rotor = 0;
    repeat (20) @(negedge clk);
    check("R4 all records seen", q.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule